// File: doc/BRIEF.md
# Self-Test Register with Pattern Generation and Signature Check

This block is one register that serves four roles during built-in self-test. It can hold the results of ordinary logic, shift its contents serially for scan access, generate pseudo-random stimulus as a linear feedback shift register, or compact the responses of the logic under test into one signature. A two-bit mode input selects the role on every clock. The parallel output always shows the register. The serial output always carries the most significant bit.

A small controller times a self-test run. A start pulse begins a run of a fixed number of clock cycles. When the run ends, the controller raises a done pulse and a pass flag. The pass flag tells whether the register matches the expected signature presented at the input. A tester uses the block in three steps: it seeds or scans in a value, pulses start while it steps the modes, and then reads done and pass.

Top module: `selftest_reg`

## Requirements
- R1: While rst is high at a clock edge, the register loads all ones, and done and pass go to 0.
- R2: With mode = 2'b00 (capture), the register loads pdata_in on each edge. pdata_out always equals the register.
- R3: With mode = 2'b01 (scan), each edge shifts the register one place toward the MSB, and scan_in enters bit 0. In every mode, scan_out equals the register MSB.
- R4: With mode = 2'b10 (pattern), each edge shifts the register toward the MSB, and the new bit 0 is the XOR of the register bits selected by TAPS (default 3'b101, so MSB XOR LSB). From 3'b111 the 3-bit states are 110, 101, 010, 100, 001, 011 and then 111 again.
- R5: With mode = 2'b11 (compaction), the next register value is the pattern-mode next value XORed bitwise with pdata_in.
- R6: An edge with start high begins a run. After the RUN_CYCLES edges that follow it (default 7), done is high for exactly the one cycle after the last of those edges, and low at all other times.
- R7: When done rises, pass is 1 if the register equals the value that expected_sig had at the final run edge, and 0 otherwise. An edge with start high clears pass. Otherwise pass holds until the next start.
- R8: A start during a run restarts the count, and this includes the final run edge. In that case no done pulse is produced for the abandoned run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | 00 capture, 01 scan, 10 pattern, 11 compaction |
| pdata_in | input | WIDTH | Parallel data / responses to compact |
| pdata_out | output | WIDTH | Register contents |
| scan_in | input | 1 | Serial data entering bit 0 in scan mode |
| scan_out | output | 1 | Register MSB |
| start | input | 1 | Begins (or restarts) a self-test run |
| expected_sig | input | WIDTH | Signature the final register value is compared with |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Result of the last completed run |

## Verification
The coincidence that matters is a start pulse that lands on the final edge of a run, the same edge on which the controller would otherwise compare and raise done. The bench provokes this on purpose and also through random start pulses during runs. It checks that the restart wins, so done stays low, pass clears, and a full new run is counted out before done appears. The register model in the bench steps through every mode in the same cycles, so a run is judged against signatures taken after mixed capture, scan, pattern and compaction steps.

// File: rtl/selftest_pkg.sv
package selftest_pkg;

    typedef enum logic [1:0] {
        MODE_CAPTURE = 2'b00,
        MODE_SCAN    = 2'b01,
        MODE_PATTERN = 2'b10,
        MODE_COMPACT = 2'b11
    } st_mode_e;

endpackage

// File: rtl/selftest_next.sv
module selftest_next
    import selftest_pkg::*;
#(
    parameter int            WIDTH = 3,
    parameter logic [WIDTH-1:0] TAPS = 3'b101
) (
    input  logic [WIDTH-1:0] state_q,
    input  logic [1:0]       mode,
    input  logic [WIDTH-1:0] pdata_in,
    input  logic             scan_in,
    output logic [WIDTH-1:0] state_d
);

    logic [WIDTH-1:0] tap_terms;
    logic             feedback;
    logic [WIDTH-1:0] shifted_scan;
    logic [WIDTH-1:0] shifted_lfsr;
    st_mode_e         mode_e;

    for (genvar i = 0; i < WIDTH; i++) begin : g_taps
        if (TAPS[i]) begin : g_on
            assign tap_terms[i] = state_q[i];
        end else begin : g_off
            assign tap_terms[i] = 1'b0;
        end
    end

    assign feedback     = ^tap_terms;
    assign shifted_scan = {state_q[WIDTH-2:0], scan_in};
    assign shifted_lfsr = {state_q[WIDTH-2:0], feedback};
    assign mode_e       = st_mode_e'(mode);

    always_comb begin
        unique case (mode_e)
            MODE_CAPTURE: state_d = pdata_in;
            MODE_SCAN:    state_d = shifted_scan;
            MODE_PATTERN: state_d = shifted_lfsr;
            MODE_COMPACT: state_d = shifted_lfsr ^ pdata_in;
            default:      state_d = pdata_in;
        endcase
    end

endmodule

// File: rtl/selftest_core.sv
module selftest_core
    import selftest_pkg::*;
#(
    parameter int            WIDTH = 3,
    parameter logic [WIDTH-1:0] TAPS = 3'b101
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic [WIDTH-1:0] pdata_in,
    input  logic             scan_in,
    output logic [WIDTH-1:0] state_q,
    output logic [WIDTH-1:0] state_next
);

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } core_t;

    core_t            core_d, core_q;
    logic [WIDTH-1:0] step_val;

    selftest_next #(
        .WIDTH (WIDTH),
        .TAPS  (TAPS)
    ) next_i (
        .state_q  (core_q.bits),
        .mode     (mode),
        .pdata_in (pdata_in),
        .scan_in  (scan_in),
        .state_d  (step_val)
    );

    always_comb begin
        core_d = core_q;
        if (rst) begin
            core_d.bits = '1;
        end else begin
            core_d.bits = step_val;
        end
    end

    always_ff @(posedge clk) begin
        core_q <= core_d;
    end

    assign state_q    = core_q.bits;
    assign state_next = core_d.bits;

    // R1: reset seeds all ones
    assert_reset_seed_R1: assert property (@(posedge clk)
        $past(rst) |-> (core_q.bits == {WIDTH{1'b1}}));

    // R2: capture loads the parallel input
    assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CAPTURE) |=> (core_q.bits == $past(pdata_in)));

    // R3: scan shifts toward MSB with scan_in at bit 0
    assert_scan_shift_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SCAN) |=>
            (core_q.bits == {$past(core_q.bits[WIDTH-2:0]), $past(scan_in)}));

    // R4: pattern mode never leaves a nonzero state for zero
    assert_pattern_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_PATTERN && core_q.bits != '0) |=> (core_q.bits != '0));

    // R4: upper bits of pattern mode are a plain shift
    assert_pattern_shift_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_PATTERN) |=>
            (core_q.bits[WIDTH-1:1] == $past(core_q.bits[WIDTH-2:0])));

    // R5: compaction is pattern step XOR data
    assert_compact_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_COMPACT) |=>
            ((core_q.bits ^ $past(pdata_in)) ==
             {$past(core_q.bits[WIDTH-2:0]), ^($past(core_q.bits) & TAPS)}));

endmodule

// File: rtl/selftest_ctrl.sv
module selftest_ctrl #(
    parameter int WIDTH      = 3,
    parameter int RUN_CYCLES = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] sig_next,
    input  logic [WIDTH-1:0] expected_sig,
    output logic             done,
    output logic             pass
);

    localparam int CNT_W = $clog2(RUN_CYCLES + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] remaining;
        logic             done;
        logic             pass;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  last_edge;

    assign last_edge = ctrl_q.busy && (ctrl_q.remaining == CNT_W'(1));

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        if (rst) begin
            ctrl_d = '0;
        end else if (start) begin
            ctrl_d.busy      = 1'b1;
            ctrl_d.remaining = CNT_W'(RUN_CYCLES);
            ctrl_d.pass      = 1'b0;
        end else if (last_edge) begin
            ctrl_d.busy      = 1'b0;
            ctrl_d.remaining = '0;
            ctrl_d.done      = 1'b1;
            ctrl_d.pass      = (sig_next == expected_sig);
        end else if (ctrl_q.busy) begin
            ctrl_d.remaining = ctrl_q.remaining - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        ctrl_q <= ctrl_d;
    end

    assign done = ctrl_q.done;
    assign pass = ctrl_q.pass;

    // R1: reset clears flags
    assert_reset_flags_R1: assert property (@(posedge clk)
        $past(rst) |-> (!done && !pass));

    // R6: done is a single-cycle pulse
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: done only follows a counted run
    assert_done_after_run_R6: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.busy || start) |=> !done);

    // R7: pass holds outside start and completion
    assert_pass_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!start && !last_edge) |=> $stable(pass));

    // R8: start wins over completion
    assert_start_wins_R8: assert property (@(posedge clk) disable iff (rst)
        start |=> (!done && !pass && ctrl_q.busy));

endmodule

// File: rtl/selftest_reg.sv
module selftest_reg
    import selftest_pkg::*;
#(
    parameter int               WIDTH      = 3,
    parameter logic [WIDTH-1:0] TAPS       = 3'b101,
    parameter int               RUN_CYCLES = (1 << WIDTH) - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic [WIDTH-1:0] pdata_in,
    output logic [WIDTH-1:0] pdata_out,
    input  logic             scan_in,
    output logic             scan_out,
    input  logic             start,
    input  logic [WIDTH-1:0] expected_sig,
    output logic             done,
    output logic             pass
);

    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_next;

    selftest_core #(
        .WIDTH (WIDTH),
        .TAPS  (TAPS)
    ) core_i (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .pdata_in   (pdata_in),
        .scan_in    (scan_in),
        .state_q    (state_q),
        .state_next (state_next)
    );

    selftest_ctrl #(
        .WIDTH      (WIDTH),
        .RUN_CYCLES (RUN_CYCLES)
    ) ctrl_i (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .sig_next     (state_next),
        .expected_sig (expected_sig),
        .done         (done),
        .pass         (pass)
    );

    assign pdata_out = state_q;
    assign scan_out  = state_q[WIDTH-1];

    // R3: serial output follows the MSB one edge after it is loaded
    assert_scan_out_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CAPTURE) |=> (scan_out == $past(pdata_in[WIDTH-1])));

endmodule

// File: tb/selftest_reg_tb_top.sv
module selftest_reg_tb_top;

    localparam int         W    = 3;
    localparam int         RUN  = 7;
    localparam logic [2:0] TAPM = 3'b101;

    logic         clk = 1'b0;
    logic         rst;
    logic [1:0]   mode;
    logic [W-1:0] pdata_in;
    logic [W-1:0] pdata_out;
    logic         scan_in;
    logic         scan_out;
    logic         start;
    logic [W-1:0] expected_sig;
    logic         done;
    logic         pass;

    int n_checks = 0;
    int n_fail   = 0;

    logic [W-1:0] m_q;
    logic         m_busy;
    int           m_cnt;
    logic         m_done;
    logic         m_pass;

    selftest_reg dut_i (
        .clk          (clk),
        .rst          (rst),
        .mode         (mode),
        .pdata_in     (pdata_in),
        .pdata_out    (pdata_out),
        .scan_in      (scan_in),
        .scan_out     (scan_out),
        .start        (start),
        .expected_sig (expected_sig),
        .done         (done),
        .pass         (pass)
    );

    always #5 clk = ~clk;

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    function automatic logic [W-1:0] next_m(logic [W-1:0] q, logic [1:0] md,
                                            logic [W-1:0] d, logic si);
        logic [W-1:0] lf;
        lf = {q[W-2:0], ^(q & TAPM)};
        case (md)
            2'b00:   return d;
            2'b01:   return {q[W-2:0], si};
            2'b10:   return lf;
            default: return lf ^ d;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(logic [1:0] md);
        case (md)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    // Drive at negedge, model at the edge, check at the next negedge
    task automatic step(logic [1:0] md, logic [W-1:0] d, logic si, logic st,
                        logic [W-1:0] ex);
        logic [W-1:0] qn;
        mode = md; pdata_in = d; scan_in = si; start = st; expected_sig = ex;
        @(posedge clk);
        qn     = next_m(m_q, md, d, si);
        m_done = 1'b0;
        if (st) begin
            m_busy = 1'b1; m_cnt = RUN; m_pass = 1'b0;
        end else if (m_busy) begin
            m_cnt--;
            if (m_cnt == 0) begin
                m_busy = 1'b0; m_done = 1'b1; m_pass = (qn == ex);
            end
        end
        m_q = qn;
        @(negedge clk);
        chk(tag_of(md), 32'(pdata_out), 32'(m_q));
        chk("R3", 32'(scan_out), 32'(m_q[W-1]));
        chk("R6", 32'(done), 32'(m_done));
        chk("R7", 32'(pass), 32'(m_pass));
    endtask

    initial begin
        logic [2:0] seq [7];
        seq = '{3'b110, 3'b101, 3'b010, 3'b100, 3'b001, 3'b011, 3'b111};
        void'($urandom(32'h5eed_0042));
        rst = 1'b1; mode = 2'b00; pdata_in = '0; scan_in = 1'b0;
        start = 1'b0; expected_sig = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_q = 3'b111; m_busy = 1'b0; m_cnt = 0; m_done = 1'b0; m_pass = 1'b0;
        chk("R1", 32'(pdata_out), 32'h7);
        chk("R1", 32'(done), 0);
        chk("R1", 32'(pass), 0);

        // R4 directed sequence from the seed
        for (int i = 0; i < 7; i++) begin
            step(2'b10, '0, 1'b0, 1'b0, '0);
            chk("R4", 32'(pdata_out), 32'(seq[i]));
        end

        for (int i = 0; i < 15; i++) step(2'b00, W'($urandom), 1'b0, 1'b0, '0);
        for (int i = 0; i < 15; i++) step(2'b01, W'($urandom), 1'($urandom), 1'b0, '0);
        for (int i = 0; i < 15; i++) step(2'b11, W'($urandom), 1'b0, 1'b0, '0);

        // R7 passing run: seed 111 at the start edge, 7 pattern edges
        step(2'b00, 3'b111, 1'b0, 1'b1, '0);
        for (int i = 0; i < RUN; i++) step(2'b10, '0, 1'b0, 1'b0, 3'b111);
        chk("R7", 32'(pass), 1);
        chk("R6", 32'(done), 1);
        for (int i = 0; i < 3; i++) step(2'b10, '0, 1'b0, 1'b0, 3'b000);
        chk("R7", 32'(pass), 1);

        // R7 failing run
        step(2'b00, 3'b111, 1'b0, 1'b1, '0);
        for (int i = 0; i < RUN; i++) step(2'b10, '0, 1'b0, 1'b0, 3'b000);
        chk("R7", 32'(pass), 0);

        // R8 restart mid-run
        step(2'b10, '0, 1'b0, 1'b1, '0);
        for (int i = 0; i < 3; i++) step(2'b11, W'($urandom), 1'b0, 1'b0, '0);
        step(2'b10, '0, 1'b0, 1'b1, '0);
        for (int i = 0; i < RUN; i++) step(2'b11, W'($urandom), 1'b0, 1'b0, '0);

        // R8 start on the final run edge
        step(2'b10, '0, 1'b0, 1'b1, '0);
        for (int i = 0; i < RUN - 1; i++) step(2'b10, '0, 1'b0, 1'b0, '0);
        step(2'b10, '0, 1'b0, 1'b1, '0);
        chk("R8", 32'(done), 0);
        for (int i = 0; i < RUN; i++) step(2'b10, '0, 1'b0, 1'b0, pdata_out);
        chk("R8", 32'(done), 1);

        for (int i = 0; i < 400; i++)
            step(2'($urandom), W'($urandom), 1'($urandom),
                 ($urandom % 9) == 0, W'($urandom));

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule